// File: doc/BRIEF.md
# Multi-Port Physical Register Free List

This block keeps the pool of physical register tags that are not currently bound to any architectural register. The rename stage asks it for up to four fresh tags per cycle, one for each instruction destination being renamed, and the commit stage hands back up to four tags per cycle. A returned tag is the mapping that an instruction replaced; it comes back once that instruction commits. A registered count of available tags is always visible, so the rename stage can stall before it asks for more tags than exist.

The pool is a circular queue of tags. An allocation pointer takes tags from the oldest end, and a reclamation pointer appends returned tags at the other end. Each pointer moves by 0 to 4 positions per cycle. After reset, physical registers 0 to 15 hold the identity mapping of the 16 architectural registers and are in use. The queue then holds tags 16 to 127 in ascending order, which is 112 free tags.

Top module: `phys_free_list`

## Requirements
- R1: After reset, `free_cnt` reads 112, and the first grant of four hands out tags 16, 17, 18 and 19 on lanes 0 to 3.
- R2: A request of n tags (0 to 4) with n not above `free_cnt` is granted: `alloc_ok` is 1, lanes 0 to n-1 of `alloc_vld` are set and no other lane is set, and the valid lanes carry distinct 7-bit tags.
- R3: A request larger than `free_cnt` is refused in full: `alloc_ok` is 0, no lane is valid, and no tag leaves the list, so a later request receives the same tags.
- R4: Tags are handed out in the order they entered the list, with lane 0 carrying the oldest one.
- R5: A reclamation lane whose valid bit (`rel_vld[j]`) is low is ignored. Valid lanes append their tags (`rel_tags[7*j +: 7]`) in ascending lane order.
- R6: At each clock edge, `free_cnt` becomes its old value minus the tags granted in that cycle plus the valid tags returned in that cycle.
- R7: A tag returned in a cycle is not counted in `free_cnt` and cannot be granted until the next cycle.
- R8: An allocation and a reclamation in the same cycle both take full effect.
- R9: The list holds all 128 tags when every tag has been returned. `free_cnt` then reads 128, and the count never exceeds 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 3 | Number of tags requested this cycle (0 to 4) |
| alloc_ok | output | 1 | Request granted this cycle |
| alloc_vld | output | 4 | Per-lane valid for the granted tags |
| alloc_tags | output | 28 | Granted tags, lane j at bits 7*j+6 to 7*j |
| rel_vld | input | 4 | Per-lane valid for returned tags |
| rel_tags | input | 28 | Returned tags, lane j at bits 7*j+6 to 7*j |
| free_cnt | output | 8 | Number of tags available for allocation |

## Verification
Allocation and reclamation can fall in the same cycle. The bench drives a grant and a partly valid set of returns in one cycle, which moves both pointers by different amounts. A scoreboard that models the queue predicts the next count and the tags seen in later grants. The hardest overlap comes when the list is empty and a tag is returned while a request is pending. The request must be refused in that cycle, and the returned tag must appear on lane 0 in the following cycle.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int FL_NUM_PHYS = 128;
  localparam int FL_NUM_ARCH = 16;
  localparam int FL_LANES    = 4;
endpackage

// File: rtl/fl_grant.sv
module fl_grant #(
  parameter int LANES = 4,
  parameter int REQ_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REQ_W-1:0] req_n,
  input  logic [CNT_W-1:0] avail,
  output logic             grant,
  output logic [LANES-1:0] lane_vld,
  output logic [REQ_W-1:0] take_n
);
  logic req_legal;

  always_comb begin
    req_legal = (int'(req_n) <= LANES);
    grant     = req_legal && (CNT_W'(req_n) <= avail);
    take_n    = grant ? req_n : '0;
    for (int i = 0; i < LANES; i++) begin
      lane_vld[i] = grant && (i < int'(req_n));
    end
  end

  // R3
  refuse_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(req_n) > avail) |-> (lane_vld == '0 && !grant));

  // R2
  lanes_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_vld & (lane_vld + LANES'(1))) == '0));
endmodule

// File: rtl/fl_pack.sv
module fl_pack #(
  parameter int LANES = 4,
  parameter int REQ_W = 3,
  parameter int PTR_W = 7
) (
  input  logic [LANES-1:0]       vld,
  input  logic [PTR_W-1:0]       tail,
  output logic [LANES*PTR_W-1:0] wr_idx,
  output logic [REQ_W-1:0]       put_n
);
  logic [REQ_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int j = 0; j < LANES; j++) begin
      wr_idx[j*PTR_W +: PTR_W] = tail + PTR_W'(acc);
      acc = acc + REQ_W'(vld[j]);
    end
    put_n = acc;
  end
endmodule

// File: rtl/fl_ring.sv
module fl_ring #(
  parameter int DEPTH    = 128,
  parameter int NUM_ARCH = 16,
  parameter int TAG_W    = 7,
  parameter int PTR_W    = 7,
  parameter int LANES    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PTR_W-1:0]       head,
  output logic [LANES*TAG_W-1:0] rd_tags,
  input  logic [LANES-1:0]       wr_en,
  input  logic [LANES*PTR_W-1:0] wr_idx,
  input  logic [LANES*TAG_W-1:0] wr_tags
);
  logic [TAG_W-1:0] mem_q   [DEPTH];
  logic [TAG_W-1:0] mem_nxt [DEPTH];
  logic             any_wr;

  always_comb begin
    for (int e = 0; e < DEPTH; e++) mem_nxt[e] = mem_q[e];
    for (int j = 0; j < LANES; j++) begin
      if (wr_en[j]) mem_nxt[wr_idx[j*PTR_W +: PTR_W]] = wr_tags[j*TAG_W +: TAG_W];
    end
    any_wr = |wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= TAG_W'((e + NUM_ARCH) % DEPTH);
    end else if (any_wr) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= mem_nxt[e];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_rd
    logic [PTR_W-1:0] idx;
    assign idx = head + PTR_W'(i);
    assign rd_tags[i*TAG_W +: TAG_W] = mem_q[idx];
  end
endmodule

// File: rtl/phys_free_list.sv
module phys_free_list #(
  parameter int NUM_PHYS = fl_pkg::FL_NUM_PHYS,
  parameter int NUM_ARCH = fl_pkg::FL_NUM_ARCH,
  parameter int LANES    = fl_pkg::FL_LANES,
  localparam int TAG_W   = $clog2(NUM_PHYS),
  localparam int PTR_W   = $clog2(NUM_PHYS),
  localparam int CNT_W   = $clog2(NUM_PHYS + 1),
  localparam int REQ_W   = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [REQ_W-1:0]       alloc_req,
  output logic                   alloc_ok,
  output logic [LANES-1:0]       alloc_vld,
  output logic [LANES*TAG_W-1:0] alloc_tags,
  input  logic [LANES-1:0]       rel_vld,
  input  logic [LANES*TAG_W-1:0] rel_tags,
  output logic [CNT_W-1:0]       free_cnt
);
  logic [PTR_W-1:0]       head_q, head_nxt, tail_q, tail_nxt;
  logic [CNT_W-1:0]       cnt_q, cnt_nxt;
  logic [CNT_W:0]         cnt_wide;
  logic [REQ_W-1:0]       take_n, put_n;
  logic [LANES*PTR_W-1:0] wr_idx;
  logic [LANES*TAG_W-1:0] head_tags;
  logic                   head_en, tail_en, cnt_en;
  logic                   dup_seen;

  fl_grant #(.LANES(LANES), .REQ_W(REQ_W), .CNT_W(CNT_W)) u_grant (
    .clk(clk), .rst_n(rst_n), .req_n(alloc_req), .avail(cnt_q),
    .grant(alloc_ok), .lane_vld(alloc_vld), .take_n(take_n));

  fl_pack #(.LANES(LANES), .REQ_W(REQ_W), .PTR_W(PTR_W)) u_pack (
    .vld(rel_vld), .tail(tail_q), .wr_idx(wr_idx), .put_n(put_n));

  fl_ring #(.DEPTH(NUM_PHYS), .NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W),
            .PTR_W(PTR_W), .LANES(LANES)) u_ring (
    .clk(clk), .rst_n(rst_n), .head(head_q), .rd_tags(head_tags),
    .wr_en(rel_vld), .wr_idx(wr_idx), .wr_tags(rel_tags));

  for (genvar i = 0; i < LANES; i++) begin : g_out
    assign alloc_tags[i*TAG_W +: TAG_W] =
      alloc_vld[i] ? head_tags[i*TAG_W +: TAG_W] : '0;
  end

  always_comb begin
    head_en  = (take_n != '0);
    tail_en  = (put_n != '0);
    cnt_en   = head_en || tail_en;
    head_nxt = head_q + PTR_W'(take_n);
    tail_nxt = tail_q + PTR_W'(put_n);
    cnt_wide = {1'b0, cnt_q} - (CNT_W+1)'(take_n) + (CNT_W+1)'(put_n);
    cnt_nxt  = cnt_wide[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= PTR_W'(NUM_PHYS - NUM_ARCH);
      cnt_q  <= CNT_W'(NUM_PHYS - NUM_ARCH);
    end else begin
      if (head_en) head_q <= head_nxt;
      if (tail_en) tail_q <= tail_nxt;
      if (cnt_en)  cnt_q  <= cnt_nxt;
    end
  end

  assign free_cnt = cnt_q;

  always_comb begin
    dup_seen = 1'b0;
    for (int a = 0; a < LANES; a++) begin
      for (int b = a + 1; b < LANES; b++) begin
        if (alloc_vld[a] && alloc_vld[b] &&
            alloc_tags[a*TAG_W +: TAG_W] == alloc_tags[b*TAG_W +: TAG_W])
          dup_seen = 1'b1;
      end
    end
  end

  // R2
  distinct_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_seen);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wide <= (CNT_W+1)'(NUM_PHYS));

  // R6
  count_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(free_cnt) == int'($past(free_cnt))
              - $countones($past(alloc_vld)) + $countones($past(rel_vld))));

  // R7
  fresh_not_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == '0) |-> (alloc_vld == '0));
endmodule

// File: tb/phys_free_list_tb.sv
`timescale 1ns/1ps
module phys_free_list_tb;
  localparam int LANES = 4;
  localparam int TAG_W = 7;

  typedef struct {
    int                     req;
    bit                     ok;
    int                     cnt;
    logic [LANES*TAG_W-1:0] tags;
    string                  rq;
  } item_t;

  logic                   clk, rst_n;
  logic [2:0]             alloc_req;
  logic                   alloc_ok;
  logic [LANES-1:0]       alloc_vld;
  logic [LANES*TAG_W-1:0] alloc_tags;
  logic [LANES-1:0]       rel_vld;
  logic [LANES*TAG_W-1:0] rel_tags;
  logic [7:0]             free_cnt;

  int checks = 0;
  int fails  = 0;
  item_t exp_q[$];
  logic [TAG_W-1:0] model_q[$];
  logic [TAG_W-1:0] busy_q[$];

  phys_free_list u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_ok(alloc_ok),
    .alloc_vld(alloc_vld), .alloc_tags(alloc_tags), .rel_vld(rel_vld),
    .rel_tags(rel_tags), .free_cnt(free_cnt));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit cond, input string rq, input string what,
                     input int act, input int expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
    end
  endtask

  task automatic step(input int req, input logic [LANES-1:0] rv,
                      input logic [LANES*TAG_W-1:0] rt, input string rq);
    item_t it;
    @(negedge clk);
    alloc_req = 3'(req);
    rel_vld   = rv;
    rel_tags  = rt;
    it.req  = req;
    it.cnt  = model_q.size();
    it.ok   = (req <= it.cnt);
    it.tags = '0;
    it.rq   = rq;
    if (it.ok) begin
      for (int i = 0; i < req; i++) begin
        it.tags[i*TAG_W +: TAG_W] = model_q[0];
        busy_q.push_back(model_q.pop_front());
      end
    end
    exp_q.push_back(it);
    for (int j = 0; j < LANES; j++) begin
      if (rv[j]) model_q.push_back(rt[j*TAG_W +: TAG_W]);
    end
  endtask

  task automatic give_back(input int n, input int req, input string rq);
    logic [LANES*TAG_W-1:0] rt = '0;
    logic [LANES-1:0] rv = '0;
    for (int j = 0; j < n; j++) begin
      rv[j] = 1'b1;
      rt[j*TAG_W +: TAG_W] = busy_q.pop_front();
    end
    step(req, rv, rt, rq);
  endtask

  initial begin : monitor
    item_t it;
    logic [LANES-1:0] mask;
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        chk(int'(free_cnt) == it.cnt, it.rq, "free_cnt", int'(free_cnt), it.cnt);
        chk(alloc_ok == it.ok, it.rq, "alloc_ok", int'(alloc_ok), int'(it.ok));
        mask = '0;
        if (it.ok) for (int i = 0; i < it.req; i++) mask[i] = 1'b1;
        chk(alloc_vld == mask, it.rq, "alloc_vld", int'(alloc_vld), int'(mask));
        for (int i = 0; i < it.req; i++) begin
          if (it.ok)
            chk(alloc_tags[i*TAG_W +: TAG_W] == it.tags[i*TAG_W +: TAG_W], it.rq,
                "tag", int'(alloc_tags[i*TAG_W +: TAG_W]),
                int'(it.tags[i*TAG_W +: TAG_W]));
        end
      end
    end
  end

  initial begin : watchdog
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    rst_n = 1'b0; alloc_req = '0; rel_vld = '0; rel_tags = '0;
    for (int t = 16; t < 128; t++) model_q.push_back(7'(t));
    for (int t = 0; t < 16; t++) busy_q.push_back(7'(t));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset count and first tags
    step(0, '0, '0, "R1");
    step(4, '0, '0, "R1");
    // R2 R4 R6 varied sizes
    step(3, '0, '0, "R2");
    step(1, '0, '0, "R4");
    step(2, '0, '0, "R6");
    step(0, '0, '0, "R6");
    // R5 R8: lanes 1 and 3 valid, 0 and 2 carry junk, with a grant of 2
    begin
      logic [LANES*TAG_W-1:0] rt;
      rt = '0;
      rt[0*TAG_W +: TAG_W] = 7'd99;
      rt[1*TAG_W +: TAG_W] = busy_q.pop_front();
      rt[2*TAG_W +: TAG_W] = 7'd98;
      rt[3*TAG_W +: TAG_W] = busy_q.pop_front();
      step(2, 4'b1010, rt, "R8");
    end
    step(0, '0, '0, "R5");
    // R4 drain to empty, returned tags come out last in order
    while (model_q.size() >= 4) step(4, '0, '0, "R4");
    step(model_q.size(), '0, '0, "R5");
    // R7 return one tag while empty and ask for one
    give_back(1, 1, "R7");
    // R3 ask for 2 with one available
    step(2, '0, '0, "R3");
    step(1, '0, '0, "R7");
    step(0, '0, '0, "R3");
    // R8 return four while granting none then grant while returning
    give_back(4, 0, "R8");
    give_back(3, 2, "R8");
    // R9 return everything
    while (busy_q.size() >= 4) give_back(4, 0, "R9");
    if (busy_q.size() > 0) give_back(busy_q.size(), 0, "R9");
    step(0, '0, '0, "R9");
    step(4, '0, '0, "R9");
    step(0, '0, '0, "R6");
    @(negedge clk);
    alloc_req = '0; rel_vld = '0;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule